// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block holds the slot status that a hotplug controller shows to system firmware. There are `NUM_BUS` selectable buses, and each bus has three 32-bit words. The first is an inserted bitmap, which records slots that gained a device while the system was running. The second is a removal-request bitmap, which records slots whose device has been asked to leave. The third is a removable-slot mask. Firmware reaches all of these through a 20-byte window of 32-bit words. A select word picks the bus. Reading the inserted word consumes it. Writing the eject word retires one slot and sends an eject command to the device side.

Device-side logic reports events on two strobe ports, one for plug and one for unplug. Each strobe carries a bus index and a slot number. Every recorded event produces a one-cycle event pulse toward the interrupt logic. A legacy mode pins the select at bus 0 and makes the inserted word non-destructive to read.

A separate bus-reset strobe starts a drain. The drain retires every pending removal request through the eject path, one slot per cycle: bus 0 upward, and on each bus the lowest slot first. As the drain finishes with each bus, it reloads that bus's removable mask from a static input.

Top module: `hp_slot_bank`

## Requirements
- R1: After `rst`:
  - every inserted and removal-request bitmap is zero;
  - the select is 0;
  - each bus's removable mask is the inverse of its 32-bit slice of `fixed_slots` (bus b at bits 32b+31..32b);
  - `evt_pulse`, `eject_valid` and `drain_busy` are low.
- R2: A read strobe returns its data on `reg_rdata` with `reg_rvalid` high in the next cycle. The word offsets are:
  - byte offset 0x04 gives the removal-request bitmap;
  - 0x08 gives zero;
  - 0x0C gives the removable mask;
  - 0x10 gives the select.
- R3: A read of offset 0x00 returns the selected bus's inserted bitmap and clears it, unless legacy mode is on.
- R4: While `legacy_mode` is high, a read of 0x00 leaves the inserted bitmap unchanged, and any write to 0x10 sets the select to 0 whatever the data.
- R5: While the select is at or above `NUM_BUS`, every read returns zero, including a read of the select itself, and eject writes do nothing.
- R6: A plug strobe with `plug_hot` high sets the slot bit in that bus's inserted bitmap and gives a one-cycle `evt_pulse` in the next cycle. With `plug_hot` low it changes nothing and gives no pulse.
- R7: An unplug strobe sets the slot bit in that bus's removal-request bitmap and gives a one-cycle `evt_pulse` in the next cycle.
- R8: A write to 0x08 with nonzero data acts on the slot given by the lowest set data bit. It clears that slot in both bitmaps of the selected bus. In the next cycle it gives `eject_valid` for one cycle, with `eject_bus` equal to the select and `eject_slot` equal to that slot.
- R9: A write of zero to 0x08 changes nothing and produces no `eject_valid`.
- R10: Plug and unplug strobes in the same cycle are both recorded, and together they give a single pulse. A plug that lands in the same cycle as a clearing read of 0x00 survives into the bitmap.
- R11: A `hp_reset` strobe raises `drain_busy` in the next cycle. The drain then does the following:
  - it ejects every pending removal-request slot, one per cycle, in order of ascending bus and then ascending slot;
  - it clears each ejected slot's bits in both bitmaps;
  - it reloads each bus's removable mask from `fixed_slots`, then drops `drain_busy`.
  Eject writes made while `drain_busy` is high are ignored.
- R12: Plug or unplug strobes whose bus index is at or above `NUM_BUS` are ignored and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Pins the select at 0 and makes inserted reads non-destructive |
| fixed_slots | input | NUM_BUS*SLOTS | Per-bus mask of slots that are not hotpluggable |
| hp_reset | input | 1 | Starts the removal drain and the mask reload |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| plug_req | input | 1 | Plug event strobe |
| plug_hot | input | 1 | High for a runtime insertion, low for a device present at power-up |
| plug_bus | input | REQ_W | Bus of the plug event |
| plug_slot | input | SLOT_W | Slot of the plug event |
| unplug_req | input | 1 | Unplug event strobe |
| unplug_bus | input | REQ_W | Bus of the unplug event |
| unplug_slot | input | SLOT_W | Slot of the unplug event |
| evt_pulse | output | 1 | One-cycle status-change event |
| eject_valid | output | 1 | One-cycle eject command |
| eject_bus | output | BUS_W | Bus of the eject command |
| eject_slot | output | SLOT_W | Slot of the eject command |
| drain_busy | output | 1 | Drain sequence in progress |

## Verification
Several kinds of internal fault show up at the ports. A corrupted bitmap bit shows on the next read of the matching word, and if it sits in the removal-request bitmap it also surfaces as an extra or missing command during the next drain. A wrong select or bank index shows as data from the wrong bus, or as nonzero data while the select is out of range, one cycle after the read strobe. A faulty lowest-bit pick or drain order shows as a wrong `eject_bus`/`eject_slot` pair in the cycle after the write, or as commands out of order in the cycle after each drain step. The scoreboard compares every read and every eject command, in order, against values that the bench computes for itself.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int REG_W = 32;
  // word index within the window (byte offset >> 2)
  localparam logic [2:0] W_UP  = 3'd0;
  localparam logic [2:0] W_DN  = 3'd1;
  localparam logic [2:0] W_EJ  = 3'd2;
  localparam logic [2:0] W_RMV = 3'd3;
  localparam logic [2:0] W_SEL = 3'd4;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/hp_bus_state.sv
module hp_bus_state #(
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] set_up,
  input  logic [SLOTS-1:0] set_dn,
  input  logic             clr_up_all,
  input  logic [SLOTS-1:0] clr_bits,
  input  logic             load_mask,
  input  logic [SLOTS-1:0] fixed,
  output logic [SLOTS-1:0] up,
  output logic [SLOTS-1:0] dn,
  output logic [SLOTS-1:0] rmv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up  <= '0;
      dn  <= '0;
      rmv <= ~fixed;
    end else begin
      up <= ((clr_up_all ? '0 : up) & ~clr_bits) | set_up;
      dn <= (dn & ~clr_bits) | set_dn;
      if (load_mask) rmv <= ~fixed;
    end
  end

  // a removal-request bit only appears when an unplug strobe named it
  p_dn_source_r7: assert property (@(posedge clk) disable iff (rst)
    ((dn & ~$past(dn)) != '0) |-> (((dn & ~$past(dn)) & ~$past(set_dn)) == '0));

  // after a clearing read, only freshly set bits may remain
  p_up_consumed_r3: assert property (@(posedge clk) disable iff (rst)
    $past(clr_up_all) |-> ((up & ~$past(set_up)) == '0));
endmodule

// File: rtl/hp_drain_seq.sv
module hp_drain_seq #(
  parameter int NUM_BUS = 4,
  parameter int SLOTS   = 32,
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NUM_BUS*SLOTS-1:0] dn_flat,
  output logic                     busy,
  output logic [BUS_W-1:0]         cur_bus,
  output logic                     go,
  output logic [SLOT_W-1:0]        slot,
  output logic                     load
);
  logic [SLOTS-1:0] dn_cur;
  logic             pend;

  assign dn_cur = dn_flat[cur_bus * SLOTS +: SLOTS];

  hp_lowbit #(.W(SLOTS)) u_pick (.vec(dn_cur), .idx(slot), .any(pend));

  assign go   = busy && pend;
  assign load = busy && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cur_bus <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cur_bus <= '0;
    end else if (load) begin
      if (cur_bus == BUS_W'(NUM_BUS - 1)) busy <= 1'b0;
      else cur_bus <= cur_bus + 1'b1;
    end
  end

  // the drain ends only after the last bus has been emptied
  p_drain_end_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cur_bus) == BUS_W'(NUM_BUS - 1)) && !$past(pend));

  // the sequence stays on a bus while it still has pending slots
  p_drain_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(go) && !$past(start)) |-> (busy && cur_bus == $past(cur_bus)));
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
  parameter int NUM_BUS = 4,
  parameter int SLOTS   = 32,
  parameter int REQ_W   = 8,
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     legacy_mode,
  input  logic [NUM_BUS*SLOTS-1:0] fixed_slots,
  input  logic                     hp_reset,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [4:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic                     reg_rvalid,
  output logic [31:0]              reg_rdata,
  input  logic                     plug_req,
  input  logic                     plug_hot,
  input  logic [REQ_W-1:0]         plug_bus,
  input  logic [SLOT_W-1:0]        plug_slot,
  input  logic                     unplug_req,
  input  logic [REQ_W-1:0]         unplug_bus,
  input  logic [SLOT_W-1:0]        unplug_slot,
  output logic                     evt_pulse,
  output logic                     eject_valid,
  output logic [BUS_W-1:0]         eject_bus,
  output logic [SLOT_W-1:0]        eject_slot,
  output logic                     drain_busy
);
  import hp_pkg::*;

  localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [31:0]      sel_q;
  logic             sel_ok;
  logic [BUS_W-1:0] sel_idx;
  logic             aligned;
  logic [2:0]       word;

  logic [SLOTS-1:0] up_v  [NUM_BUS];
  logic [SLOTS-1:0] dn_v  [NUM_BUS];
  logic [SLOTS-1:0] rmv_v [NUM_BUS];
  logic [NUM_BUS*SLOTS-1:0] dn_flat;

  logic              plug_ok, unplug_ok;
  logic              rd_clr, wr_ej, wr_sel;
  logic [SLOT_W-1:0] wr_slot;
  logic              wr_any;
  logic              drain_go, drain_load;
  logic [BUS_W-1:0]  drain_bus;
  logic [SLOT_W-1:0] drain_slot;
  logic [31:0]       rd_mux;

  assign sel_ok  = sel_q < 32'(NUM_BUS);
  assign sel_idx = sel_q[BUS_W-1:0];
  assign aligned = reg_addr[1:0] == 2'b00;
  assign word    = reg_addr[4:2];

  assign plug_ok   = plug_req && plug_hot && (plug_bus < REQ_W'(NUM_BUS));
  assign unplug_ok = unplug_req && (unplug_bus < REQ_W'(NUM_BUS));

  hp_lowbit #(.W(SLOTS)) u_wpick (
    .vec(reg_wdata[SLOTS-1:0]), .idx(wr_slot), .any(wr_any));

  assign rd_clr = reg_rd && aligned && word == W_UP && sel_ok && !legacy_mode;
  assign wr_ej  = reg_wr && aligned && word == W_EJ && sel_ok && wr_any && !drain_busy;
  assign wr_sel = reg_wr && aligned && word == W_SEL;

  hp_drain_seq #(.NUM_BUS(NUM_BUS), .SLOTS(SLOTS)) u_drain (
    .clk(clk), .rst(rst), .start(hp_reset), .dn_flat(dn_flat),
    .busy(drain_busy), .cur_bus(drain_bus), .go(drain_go),
    .slot(drain_slot), .load(drain_load));

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [SLOTS-1:0] set_up, set_dn, clr_bits;
    assign set_up = (plug_ok && plug_bus == REQ_W'(b)) ? (ONE << plug_slot) : '0;
    assign set_dn = (unplug_ok && unplug_bus == REQ_W'(b)) ? (ONE << unplug_slot) : '0;
    assign clr_bits = ((wr_ej && sel_idx == BUS_W'(b)) ? (ONE << wr_slot) : '0)
                    | ((drain_go && drain_bus == BUS_W'(b)) ? (ONE << drain_slot) : '0);

    hp_bus_state #(.SLOTS(SLOTS)) u_state (
      .clk(clk), .rst(rst),
      .set_up(set_up), .set_dn(set_dn),
      .clr_up_all(rd_clr && sel_idx == BUS_W'(b)),
      .clr_bits(clr_bits),
      .load_mask(drain_load && drain_bus == BUS_W'(b)),
      .fixed(fixed_slots[b*SLOTS +: SLOTS]),
      .up(up_v[b]), .dn(dn_v[b]), .rmv(rmv_v[b]));

    assign dn_flat[b*SLOTS +: SLOTS] = dn_v[b];
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ok && aligned) begin
      case (word)
        W_UP:    rd_mux = 32'(up_v[sel_idx]);
        W_DN:    rd_mux = 32'(dn_v[sel_idx]);
        W_RMV:   rd_mux = 32'(rmv_v[sel_idx]);
        W_SEL:   rd_mux = sel_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      reg_rvalid  <= 1'b0;
      reg_rdata   <= '0;
      evt_pulse   <= 1'b0;
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      if (wr_sel) sel_q <= legacy_mode ? 32'd0 : reg_wdata;
      reg_rvalid  <= reg_rd;
      reg_rdata   <= reg_rd ? rd_mux : '0;
      evt_pulse   <= plug_ok || unplug_ok;
      eject_valid <= drain_go || wr_ej;
      eject_bus   <= drain_go ? drain_bus : sel_idx;
      eject_slot  <= drain_go ? drain_slot : wr_slot;
    end
  end

  // every pulse traces back to a runtime plug or an unplug strobe
  p_evt_cause_r6: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |-> ($past(plug_req && plug_hot) || $past(unplug_req)));

  // no eject command without a drain step or a nonzero eject write
  p_eject_cause_r9: assert property (@(posedge clk) disable iff (rst)
    eject_valid |-> ($past(drain_busy) || ($past(reg_wr) && $past(reg_wdata) != 32'd0)));

  // an out-of-range select never lets data out
  p_oor_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rvalid && $past(sel_q) >= 32'(NUM_BUS)) |-> reg_rdata == 32'd0);

  // legacy select writes always land on bus 0
  p_legacy_sel_r4: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && legacy_mode && aligned && word == W_SEL) |-> sel_q == 32'd0);
endmodule

// File: tb/hp_slot_bank_test.sv
module hp_slot_bank_test;
  localparam int NB = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1, legacy_mode = 1'b0, hp_reset = 1'b0;
  logic [NB*32-1:0] fixed_slots;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_rvalid;
  logic [31:0]   reg_rdata;
  logic          plug_req = 1'b0, plug_hot = 1'b0, unplug_req = 1'b0;
  logic [7:0]    plug_bus = '0, unplug_bus = '0;
  logic [4:0]    plug_slot = '0, unplug_slot = '0;
  logic          evt_pulse, eject_valid, drain_busy;
  logic [1:0]    eject_bus;
  logic [4:0]    eject_slot;

  hp_slot_bank #(.NUM_BUS(NB)) uut (.*);

  int total = 0, bad = 0;
  logic [31:0] rd_q[$];
  string       rd_tag[$];
  logic [31:0] ej_q[$];
  string       ej_tag[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (rd_q.size() == 0) check("R2 unexpected read data", 32'd1, 32'd0);
      else check(rd_tag.pop_front(), reg_rdata, rd_q.pop_front());
    end
    if (eject_valid) begin
      if (ej_q.size() == 0) check("R9 unexpected eject", {25'd0, eject_bus, eject_slot}, 32'hFFFF_FFFF);
      else check(ej_tag.pop_front(), {25'd0, eject_bus, eject_slot}, ej_q.pop_front());
    end
  end

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic expect_ej(int b, int s, string tag);
    ej_q.push_back(32'(b * 32 + s)); ej_tag.push_back(tag);
  endtask

  task automatic plug(int b, int s, logic hot, logic exp_evt, string tag);
    @(negedge clk);
    plug_req = 1'b1; plug_hot = hot; plug_bus = 8'(b); plug_slot = 5'(s);
    @(negedge clk);
    plug_req = 1'b0;
    check(tag, {31'd0, evt_pulse}, {31'd0, exp_evt});
  endtask

  task automatic unplug(int b, int s, logic exp_evt, string tag);
    @(negedge clk);
    unplug_req = 1'b1; unplug_bus = 8'(b); unplug_slot = 5'(s);
    @(negedge clk);
    unplug_req = 1'b0;
    check(tag, {31'd0, evt_pulse}, {31'd0, exp_evt});
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    fixed_slots = {32'hFFFF_0000, 32'h0000_0000, 32'h8000_0000, 32'h0000_0003};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 evt idle", {31'd0, evt_pulse}, 32'd0);
    check("R1 eject idle", {31'd0, eject_valid}, 32'd0);
    check("R1 drain idle", {31'd0, drain_busy}, 32'd0);
    rd(5'h10, 32'd0, "R1 select reset");
    rd(5'h00, 32'd0, "R1 inserted reset");
    rd(5'h04, 32'd0, "R1 removal reset");
    rd(5'h0C, 32'hFFFF_FFFC, "R1 removable mask bus0");
    rd(5'h08, 32'd0, "R2 features read zero");

    // R6 / R3
    plug(0, 5, 1'b1, 1'b1, "R6 hot plug event");
    @(negedge clk);
    check("R6 event is one cycle", {31'd0, evt_pulse}, 32'd0);
    rd(5'h00, 32'h20, "R3 inserted read");
    rd(5'h00, 32'h0, "R3 inserted cleared");
    plug(0, 7, 1'b0, 1'b0, "R6 boot device no event");
    rd(5'h00, 32'h0, "R6 boot device not recorded");

    // R7
    unplug(0, 9, 1'b1, "R7 unplug event");
    rd(5'h04, 32'h200, "R7 removal bit");
    rd(5'h04, 32'h200, "R2 removal read not destructive");

    // R8: eject lowest set bit, clears both bitmaps
    plug(0, 9, 1'b1, 1'b1, "R6 plug slot9");
    expect_ej(0, 9, "R8 eject bus0 slot9");
    wr(5'h08, 32'h0000_0600);
    rd(5'h04, 32'h0, "R8 removal bit cleared");
    rd(5'h00, 32'h0, "R8 inserted bit cleared");

    // R9
    wr(5'h08, 32'h0);
    @(negedge clk);
    check("R9 zero eject no command", {31'd0, eject_valid}, 32'd0);

    // bus 1
    wr(5'h10, 32'd1);
    rd(5'h10, 32'd1, "R2 select readback");
    rd(5'h0C, 32'h7FFF_FFFF, "R1 removable mask bus1");
    unplug(1, 31, 1'b1, "R7 unplug bus1 slot31");
    rd(5'h04, 32'h8000_0000, "R7 removal bus1");

    // R5 out-of-range select
    wr(5'h10, 32'd7);
    rd(5'h10, 32'd0, "R5 select read zero");
    rd(5'h04, 32'd0, "R5 removal read zero");
    rd(5'h0C, 32'd0, "R5 mask read zero");
    wr(5'h08, 32'd1);
    @(negedge clk);
    check("R5 eject ignored", {31'd0, eject_valid}, 32'd0);
    wr(5'h10, 32'd1);
    rd(5'h04, 32'h8000_0000, "R5 bus1 state kept");

    // R10 simultaneous strobes
    @(negedge clk);
    plug_req = 1'b1; plug_hot = 1'b1; plug_bus = 8'd2; plug_slot = 5'd3;
    unplug_req = 1'b1; unplug_bus = 8'd2; unplug_slot = 5'd4;
    @(negedge clk);
    plug_req = 1'b0; unplug_req = 1'b0;
    check("R10 single event", {31'd0, evt_pulse}, 32'd1);
    @(negedge clk);
    check("R10 event drops", {31'd0, evt_pulse}, 32'd0);
    wr(5'h10, 32'd2);
    rd(5'h00, 32'h8, "R10 plug recorded");
    rd(5'h04, 32'h10, "R10 unplug recorded");
    plug(2, 6, 1'b1, 1'b1, "R6 plug bus2 slot6");
    @(negedge clk);
    rd_q.push_back(32'h40); rd_tag.push_back("R10 read with concurrent plug");
    reg_rd = 1'b1; reg_addr = 5'h00;
    plug_req = 1'b1; plug_hot = 1'b1; plug_bus = 8'd2; plug_slot = 5'd7;
    @(negedge clk);
    reg_rd = 1'b0; plug_req = 1'b0;
    rd(5'h00, 32'h80, "R10 concurrent plug survives");

    // R12
    plug(9, 0, 1'b1, 1'b0, "R12 plug bad bus ignored");
    unplug(4, 0, 1'b0, "R12 unplug bad bus ignored");

    // R4 legacy
    legacy_mode = 1'b1;
    plug(2, 1, 1'b1, 1'b1, "R6 plug bus2 slot1");
    rd(5'h00, 32'h2, "R4 legacy inserted read");
    rd(5'h00, 32'h2, "R4 legacy inserted kept");
    wr(5'h10, 32'd3);
    rd(5'h10, 32'd0, "R4 legacy select forced 0");
    legacy_mode = 1'b0;
    wr(5'h10, 32'd2);
    rd(5'h00, 32'h2, "R3 read after legacy");
    rd(5'h00, 32'h0, "R3 cleared after legacy");

    // R11 drain
    unplug(0, 4, 1'b1, "R7 unplug bus0 slot4");
    unplug(0, 2, 1'b1, "R7 unplug bus0 slot2");
    unplug(3, 0, 1'b1, "R7 unplug bus3 slot0");
    fixed_slots[2*32 +: 32] = 32'h0000_00FF;
    rd(5'h0C, 32'hFFFF_FFFF, "R11 mask not reloaded before drain");
    expect_ej(0, 2, "R11 drain bus0 slot2");
    expect_ej(0, 4, "R11 drain bus0 slot4");
    expect_ej(1, 31, "R11 drain bus1 slot31");
    expect_ej(2, 4, "R11 drain bus2 slot4");
    expect_ej(3, 0, "R11 drain bus3 slot0");
    @(negedge clk);
    hp_reset = 1'b1;
    @(negedge clk);
    hp_reset = 1'b0;
    check("R11 busy raised", {31'd0, drain_busy}, 32'd1);
    wr(5'h08, 32'h1);
    for (int i = 0; i < 50 && drain_busy; i++) @(negedge clk);
    check("R11 busy dropped", {31'd0, drain_busy}, 32'd0);
    rd(5'h0C, 32'hFFFF_FF00, "R11 mask reloaded bus2");
    rd(5'h04, 32'h0, "R11 bus2 drained");
    wr(5'h10, 32'd0);
    rd(5'h04, 32'h0, "R11 bus0 drained");
    wr(5'h10, 32'd3);
    rd(5'h04, 32'h0, "R11 bus3 drained");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", 32'(rd_q.size()), 32'd0);
    check("R8 all ejects seen", 32'(ej_q.size()), 32'd0);
    finish_run();
  end
endmodule